// File: doc/BRIEF.md
# IDE PIO Command Strobe Timer

This block produces the read/write command strobe for one IDE channel that carries two drives. Each drive owns a 16-bit timing word. It sets how many clocks the strobe stays asserted, how many clocks of recovery follow, and whether the drive's ready line may stretch the strobe. One timing clock is one period of a 30 ns clock. Both counts are stored as the clock count minus one in 5-bit fields, so each runs from 1 to 32 clocks.

A transfer starts with a one-clock request and a drive select while the block is idle. On acceptance the block copies the selected drive's timing word. It runs ACTIVE (strobe high), then optionally WAIT (strobe held high while the ready line is low), then RECOVER (strobe low). After that it gives a one-clock DONE pulse and returns to IDLE. The transitions are:
- IDLE→ACTIVE on a request.
- ACTIVE→WAIT when the active count is spent, ready checking is on and ready is low.
- ACTIVE→RECOVER when the active count is spent otherwise.
- WAIT→RECOVER when ready goes high or the wait limit is reached.
- RECOVER→DONE when the recovery count is spent.
- DONE→IDLE always.

A wait that reaches the limit sets a sticky timeout flag. The timing words are written and read through a word-addressed configuration port. The parameter `CHANNEL` places the two words at 0x44/0x48 (channel 0) or at 0x4C/0x50 (channel 1).

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset both timing words read 0x0909, which is 10 active and 10 recovery clocks with ready checking off. For channel 0, drive 0 is at address 0x44 and drive 1 at 0x48. For channel 1 they are at 0x4C and 0x50.
- R2: Timing word layout: bits 12:8 = active clocks − 1, bits 4:0 = recovery clocks − 1, bit 6 = ready-check enable. All other bits read back as 0, whatever was written to them.
- R3: A write to any other address changes neither timing word, and a read of any other address returns 0.
- R4: With ready checking off, the strobe is high for exactly (bits 12:8)+1 clocks after the acceptance edge, whatever the ready line does.
- R5: After the strobe falls, busy stays high with strobe low for (bits 4:0)+1 clocks. Then xfer_done is high for exactly one clock, and on the next clock the block is idle (busy low).
- R6: With ready checking on, if ready is low at the end of the active count, the strobe stays high until the first clock edge at which ready is sampled high. The strobe never falls before the active count ends.
- R7: If ready stays low for 256 WAIT clocks, the block leaves WAIT for recovery and sets rdy_timeout. rdy_timeout stays set until reset. If ready rises on the same edge that the limit is reached, the flag is not set.
- R8: A request is accepted only in IDLE. A request raised while busy has no effect: the cycle timing is unchanged, and the block is idle on the clock after xfer_done.
- R9: The drive select and the selected timing word are captured at acceptance. A later change of drive_sel, or a register write on the acceptance edge itself, does not alter the running cycle.
- R10: The word 0x0240 gives 3 active clocks, 1 recovery clock and ready checking on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (30 ns per timing unit) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| xfer_req | input | 1 | Transfer request, accepted only in IDLE |
| drive_sel | input | 1 | Drive whose timing word is used |
| iordy | input | 1 | Drive ready line, high = ready |
| strobe | output | 1 | Command strobe, high = asserted |
| xfer_done | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | High from acceptance through DONE |
| rdy_timeout | output | 1 | Sticky ready-wait timeout flag |

## Verification
Two functions can land in the same clock: a configuration write to the selected drive's word, and acceptance of a request for that drive. The bench provokes this by raising the request and a write of 0x0240 on the same edge while the word still holds 0x0909. It then requires the running cycle to show 10 active and 10 recovery clocks, and the next cycle to show 3 and 1. A second overlap is a ready rise on the edge where the wait limit is reached. The bench checks that this case ends without setting the timeout flag.

// File: rtl/ide_tmg_pkg.sv
package ide_tmg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_WAIT,
        ST_RECOVER,
        ST_DONE
    } tmg_state_t;

    localparam int          CNT_W     = 5;
    localparam int          WORD_W    = 16;
    localparam logic [15:0] CTL_MASK  = 16'h1F5F;
    localparam logic [15:0] CTL_RESET = 16'h0909;

    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
        logic             rdy_en;
    } tmg_cfg_t;

    function automatic tmg_cfg_t ctl_unpack(input logic [WORD_W-1:0] w);
        tmg_cfg_t c;
        c.act    = w[12:8];
        c.rec    = w[4:0];
        c.rdy_en = w[6];
        return c;
    endfunction

endpackage

// File: rtl/ide_drvctl_regs.sv
module ide_drvctl_regs
    import ide_tmg_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          NUM_DRV = 2,
    parameter logic [7:0]  BASE    = 8'h44,
    parameter int          STRIDE  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [WORD_W-1:0]              cfg_wdata,
    output logic [WORD_W-1:0]              cfg_rdata,
    output logic [NUM_DRV-1:0][WORD_W-1:0] ctl_words
);

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(BASE) + d * STRIDE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_words[d] <= CTL_RESET;
            end else if (cfg_wr && (cfg_addr == MY_ADDR)) begin
                ctl_words[d] <= cfg_wdata & CTL_MASK;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int d = 0; d < NUM_DRV; d++) begin
            if (cfg_addr == ADDR_W'(int'(BASE) + d * STRIDE)) begin
                cfg_rdata = ctl_words[d];
            end
        end
    end

endmodule

// File: rtl/ide_strobe_fsm.sv
module ide_strobe_fsm
    import ide_tmg_pkg::*;
#(
    parameter int WAIT_LIMIT = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  tmg_cfg_t cfg_in,
    input  logic     iordy,
    output logic     strobe,
    output logic     done,
    output logic     busy,
    output logic     timeout
);

    localparam int WCNT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(WAIT_LIMIT - 1);

    tmg_state_t        state, state_nx;
    tmg_cfg_t          snap;
    logic [CNT_W-1:0]  cnt;
    logic [WCNT_W-1:0] wcnt;
    logic              tmo_q;

    // state register and cycle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            snap  <= '0;
            cnt   <= '0;
            wcnt  <= '0;
            tmo_q <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        snap <= cfg_in;
                        cnt  <= cfg_in.act;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt  <= snap.rec;
                        wcnt <= '0;
                    end
                end
                ST_WAIT: begin
                    wcnt <= wcnt + 1'b1;
                    if (!iordy && (wcnt == WCNT_LAST)) begin
                        tmo_q <= 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req) state_nx = ST_ACTIVE;
            ST_ACTIVE:  if (cnt == '0) state_nx = (snap.rdy_en && !iordy) ? ST_WAIT : ST_RECOVER;
            ST_WAIT:    if (iordy || (wcnt == WCNT_LAST)) state_nx = ST_RECOVER;
            ST_RECOVER: if (cnt == '0) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        strobe  = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        timeout = tmo_q;
        unique case (state)
            ST_IDLE:    busy   = 1'b0;
            ST_ACTIVE:  strobe = 1'b1;
            ST_WAIT:    strobe = 1'b1;
            ST_RECOVER: ;
            ST_DONE:    done   = 1'b1;
            default:    busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
    import ide_tmg_pkg::*;
#(
    parameter int CHANNEL    = 0,
    parameter int WAIT_LIMIT = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        xfer_req,
    input  logic        drive_sel,
    input  logic        iordy,
    output logic        strobe,
    output logic        xfer_done,
    output logic        busy,
    output logic        rdy_timeout
);

    localparam int         NUM_DRV = 2;
    localparam logic [7:0] BASE    = (CHANNEL != 0) ? 8'h4C : 8'h44;

    logic [NUM_DRV-1:0][WORD_W-1:0] ctl_words;
    tmg_cfg_t                       sel_cfg;

    ide_drvctl_regs #(
        .ADDR_W  (8),
        .NUM_DRV (NUM_DRV),
        .BASE    (BASE),
        .STRIDE  (4)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_words (ctl_words)
    );

    assign sel_cfg = ctl_unpack(ctl_words[drive_sel]);

    ide_strobe_fsm #(
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (xfer_req),
        .cfg_in  (sel_cfg),
        .iordy   (iordy),
        .strobe  (strobe),
        .done    (xfer_done),
        .busy    (busy),
        .timeout (rdy_timeout)
    );

endmodule

// File: rtl/ide_strobe_timer_chk.sv
module ide_strobe_timer_chk
    import ide_tmg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_rdata,
    input logic        xfer_req,
    input logic        strobe,
    input logic        xfer_done,
    input logic        busy,
    input logic        rdy_timeout
);

    a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CTL_MASK) == 16'h0000);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r5_done_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !strobe);

    a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !busy);

    a_r8_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_req) |=> strobe);

    a_r8_strobe_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_timeout |=> rdy_timeout);

    a_r7_timeout_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_timeout) |-> (!strobe && $past(strobe)));

endmodule

bind ide_strobe_timer ide_strobe_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .xfer_req    (xfer_req),
    .strobe      (strobe),
    .xfer_done   (xfer_done),
    .busy        (busy),
    .rdy_timeout (rdy_timeout)
);

// File: tb/ide_strobe_timer_tb.sv
module ide_strobe_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [15:0] cfg_wdata = 16'h0000;
    logic [15:0] cfg_rdata;
    logic        xfer_req = 1'b0;
    logic        drive_sel = 1'b0;
    logic        iordy = 1'b1;
    logic        strobe, xfer_done, busy, rdy_timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] shadow [2];

    always #5 clk = ~clk;

    ide_strobe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_req(xfer_req),
        .drive_sel(drive_sel), .iordy(iordy), .strobe(strobe),
        .xfer_done(xfer_done), .busy(busy), .rdy_timeout(rdy_timeout)
    );

    function automatic int exp_high(int a, bit en, int d);
        if (!en || d <= a + 1) return a + 1;
        if (d > a + 257) return a + 257;
        return d;
    endfunction

    function automatic bit exp_tmo(int a, bit en, int d);
        return en && (d > a + 257);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        shadow[0] = 16'h0909;
        shadow[1] = 16'h0909;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // run one transfer; ready rises at sample index d; drive_sel flips and
    // a stray request pulses during the cycle
    task automatic xfer(bit drv, int d, logic [15:0] w, string tag,
                        bit wr_same = 0, logic [15:0] wr_val = 16'h0);
        int hi = 0, rc = 0, dn = 0;
        int a = int'(w[12:8]);
        int r = int'(w[4:0]);
        bit en = w[6];
        drive_sel = drv;
        xfer_req  = 1'b1;
        if (wr_same) begin
            cfg_wr = 1'b1; cfg_addr = drv ? 8'h48 : 8'h44; cfg_wdata = wr_val;
        end
        @(negedge clk);
        xfer_req = 1'b0;
        cfg_wr   = 1'b0;
        for (int k = 1; k < 2000; k++) begin
            iordy = (k >= d);
            if (k == 2) begin drive_sel = ~drv; xfer_req = 1'b1; end
            if (k == 3) xfer_req = 1'b0;
            if (strobe) hi++;
            else if (xfer_done) begin dn++; break; end
            else if (busy) rc++;
            @(negedge clk);
        end
        xfer_req = 1'b0;
        check({tag, " R4/R6 strobe clocks"}, hi, exp_high(a, en, d));
        check({tag, " R5 recovery clocks"}, rc, r + 1);
        check({tag, " R5 done pulse"}, dn, 1);
        check({tag, " R7 timeout flag"}, int'(rdy_timeout), int'(exp_tmo(a, en, d)));
        @(negedge clk);
        iordy = 1'b1;
        check({tag, " R8 idle after done"}, int'(busy), 0);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        do_reset();

        rd(8'h44, v); check("R1 drive0 reset", v, 16'h0909);
        rd(8'h48, v); check("R1 drive1 reset", v, 16'h0909);
        check("R7 timeout clear at reset", int'(rdy_timeout), 0);
        check("R8 idle at reset", int'(busy), 0);

        wr(8'h48, 16'hFFFF);
        rd(8'h48, v); check("R2 unused bits zero", v, 16'h1F5F);
        wr(8'h4C, 16'h1234);
        wr(8'h40, 16'h0000);
        rd(8'h44, v); check("R3 stray write drive0", v, 16'h0909);
        rd(8'h48, v); check("R3 stray write drive1", v, 16'h1F5F);
        rd(8'h4C, v); check("R3 unmapped read", v, 16'h0000);
        shadow[1] = 16'h1F5F;

        // R4: default timing with ready low, check disabled
        xfer(1'b0, 500, 16'h0909, "dflt");
        // R9: write on acceptance edge is not seen by running cycle
        xfer(1'b0, 0, 16'h0909, "R9 same-edge", 1'b1, 16'h0240);
        shadow[0] = 16'h0240;
        // R10: fast setting, ready low for a while
        xfer(1'b0, 0, 16'h0240, "R10 fast");
        xfer(1'b0, 9, 16'h0240, "R10 stretched R6");
        // R7 boundary: ready rises on the limit edge
        xfer(1'b0, 3 + 256, 16'h0240, "R7 edge");
        // R9: drive1 with drive_sel flipped mid-cycle
        xfer(1'b1, 0, 16'h1F5F, "R9 drv1");

        // random mix
        for (int i = 0; i < 24; i++) begin
            bit dv = 1'($urandom_range(0, 1));
            logic [15:0] w = 16'($urandom());
            int d = int'($urandom_range(0, 48));
            wr(dv ? 8'h48 : 8'h44, w);
            shadow[dv] = w & 16'h1F5F;
            rd(dv ? 8'h48 : 8'h44, v);
            check("R2 random readback", v, shadow[dv]);
            xfer(dv, d, shadow[dv], "rand");
        end

        // R7 timeout
        wr(8'h44, 16'h0240);
        xfer(1'b0, 100000, 16'h0240, "R7 timeout");
        repeat (3) @(negedge clk);
        check("R7 timeout sticky", int'(rdy_timeout), 1);
        do_reset();
        check("R7 timeout cleared", int'(rdy_timeout), 0);
        rd(8'h44, v); check("R1 reset again", v, 16'h0909);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule